// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Block Mover

This block copies a run of words between one I/O device and memory without the CPU doing the copying. Software sets it up through a small register port. It loads a start address and a word count, then writes a control word. The control word picks the direction and the transfer mode and launches the run. After that the block asks the CPU for the system buses with a request/grant handshake. It drives the memory address, the data and a read or write strobe only while the grant is held. Each word is paced by a request/acknowledge pair on the device side.

There are two transfer modes. Burst mode keeps the bus for the whole block. Cycle-stealing mode gives the bus back after every word and asks for it again only when the device next asks for service. When the count runs out, the block raises an interrupt. The interrupt stays up until software writes the control register. The remaining count can be read at any time to follow progress.

Top module: `dma_engine`

## Requirements
- R1: Register accesses take effect only while `cpu_sel` is high. `cpu_rsel` picks the register: 0 = start address, 1 = word count, 2 = control/status. `cpu_rdata` reads 0 while `cpu_sel` is low, and also for code 3.
- R2: Control write bits: bit 0 launches a run, bit 1 sets the direction (0 = memory read toward the device, 1 = device toward memory write), bit 2 sets the mode (0 = burst, 1 = cycle stealing). A read of code 2 returns busy in bit 0, direction in bit 1, mode in bit 2 and the interrupt in bit 3.
- R3: `bus_oe`, `mem_rd` and `mem_wr` are high only while `bus_grant` and `bus_req` are both high. `mem_rd` and `mem_wr` are never high together.
- R4: To give the bus back, `bus_req` drops first and the block then waits for `bus_grant` to go low. `bus_req` is never high in the cycle `bus_grant` falls. While the block waits for a device request, `bus_req` stays low.
- R5: In burst mode `bus_req` rises once per run. With `dev_req` held high, the block moves one word in each of consecutive cycles.
- R6: In cycle-stealing mode exactly one word moves per grant. A run of N words raises `bus_req` N times.
- R7: Each word moved raises the address register by one and lowers the count by one. Words go to consecutive addresses starting at the programmed address. The run ends when the count reaches zero.
- R8: Each word takes one granted cycle with `dev_req` high, and `dev_ack` pulses in that same cycle. For direction 0, `mem_rd` is high and `dev_wdata` equals `mem_rdata`. For direction 1, `mem_wr` is high and `mem_wdata` equals `dev_rdata`.
- R9: At the end of a run `irq` rises after the bus is given back. It stays high until any control write clears it.
- R10: A launch with a count of zero raises `irq` on the clock edge of the write, and `bus_req` is never raised.
- R11: While a run is busy, writes to the address and count registers and launch requests are ignored. The count stays readable at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Block select for register access |
| cpu_rsel | input | 2 | Register code |
| cpu_we | input | 1 | Write enable for the register port |
| cpu_wdata | input | RW | Register write data |
| cpu_rdata | output | RW | Register read data |
| irq | output | 1 | Completion interrupt |
| bus_req | output | 1 | Request for the system buses |
| bus_grant | input | 1 | Grant from the CPU |
| bus_oe | output | 1 | Bus output enables (high only while owning the bus) |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Data written to memory |
| mem_rdata | input | DW | Data read from memory |
| dev_req | input | 1 | Device service request |
| dev_ack | output | 1 | Device acknowledge, one pulse per word |
| dev_rdata | input | DW | Data from the device |
| dev_wdata | output | DW | Data to the device |

## Verification
A sequencer stuck in the wrong state shows within a few cycles. It appears as a request edge count that differs from the word count in cycle-stealing mode, or as a gap between strobes in burst mode. A wrong address or count register shows on the first strobed word as an out-of-order `mem_addr`, and at the end as a read-back that is not start+N and 0. A wrong interrupt or busy state shows at once in the control/status read. Errors in the lock on busy writes show only when software writes during a run, so the bench writes mid-run while the device is idle and reads the registers back before the device resumes.

// File: rtl/dma_pkg.sv
package dma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT_DEV,
      ST_ASK,
      ST_MOVE,
      ST_GIVE_BACK
   } seq_state_t;

   localparam logic [1:0] SEL_ADDR  = 2'd0;
   localparam logic [1:0] SEL_COUNT = 2'd1;
   localparam logic [1:0] SEL_CTRL  = 2'd2;

   localparam int CB_GO   = 0;
   localparam int CB_DIR  = 1;
   localparam int CB_MODE = 2;
   localparam int CB_IRQ  = 3;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
   import dma_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int RW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_sel,
   input  logic [1:0]    cpu_rsel,
   input  logic          cpu_we,
   input  logic [RW-1:0] cpu_wdata,
   output logic [RW-1:0] cpu_rdata,
   input  logic          busy,
   input  logic          word_done,
   input  logic          finish,
   output logic [AW-1:0] cur_addr,
   output logic          last_word,
   output logic          dir,
   output logic          mode,
   output logic          launch,
   output logic          irq
);
   localparam int STAT_W = 4;

   logic [AW-1:0] addr_q;
   logic [CW-1:0] count_q;
   logic          dir_q, mode_q, irq_q;
   logic          wr_any, wr_addr, wr_count, wr_ctrl, zero_go;
   logic [STAT_W-1:0] status;

   initial begin
      if (AW > RW || CW > RW || RW < STAT_W)
         $fatal(1, "dma_cfg_regs: register width too small");
   end

   assign wr_any   = cpu_sel && cpu_we;
   assign wr_addr  = wr_any && cpu_rsel == SEL_ADDR  && !busy;
   assign wr_count = wr_any && cpu_rsel == SEL_COUNT && !busy;
   assign wr_ctrl  = wr_any && cpu_rsel == SEL_CTRL;
   assign launch   = wr_ctrl && !busy && cpu_wdata[CB_GO] && count_q != '0;
   assign zero_go  = wr_ctrl && !busy && cpu_wdata[CB_GO] && count_q == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         count_q <= '0;
         dir_q   <= 1'b0;
         mode_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (wr_addr)        addr_q <= cpu_wdata[AW-1:0];
         else if (word_done) addr_q <= addr_q + 1'b1;

         if (wr_count)       count_q <= cpu_wdata[CW-1:0];
         else if (word_done) count_q <= count_q - 1'b1;

         if (wr_ctrl && !busy) begin
            dir_q  <= cpu_wdata[CB_DIR];
            mode_q <= cpu_wdata[CB_MODE];
         end

         if (finish)       irq_q <= 1'b1;
         else if (wr_ctrl) irq_q <= zero_go;
      end
   end

   assign status = {irq_q, mode_q, dir_q, busy};

   always_comb begin
      cpu_rdata = '0;
      if (cpu_sel) begin
         unique case (cpu_rsel)
            SEL_ADDR:  cpu_rdata = RW'(addr_q);
            SEL_COUNT: cpu_rdata = RW'(count_q);
            SEL_CTRL:  cpu_rdata = RW'(status);
            default:   cpu_rdata = '0;
         endcase
      end
   end

   assign cur_addr  = addr_q;
   assign last_word = count_q == CW'(1);
   assign dir       = dir_q;
   assign mode      = mode_q;
   assign irq       = irq_q;

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> count_q == $past(count_q) - 1'b1); // R7
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      word_done |=> addr_q == $past(addr_q) + 1'b1); // R7
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !wr_ctrl) |=> irq_q); // R9
   AST_BUSY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !word_done) |=> count_q == $past(count_q)); // R11
endmodule

// File: rtl/dma_seq.sv
module dma_seq
   import dma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic mode,
   input  logic last_word,
   input  logic dev_req,
   input  logic bus_grant,
   output logic bus_req,
   output logic in_move,
   output logic word_done,
   output logic finish,
   output logic busy
);
   seq_state_t state_q, state_d;
   logic       ended_q;

   assign bus_req   = state_q == ST_ASK || state_q == ST_MOVE;
   assign in_move   = state_q == ST_MOVE;
   assign word_done = in_move && bus_grant && dev_req;
   assign finish    = state_q == ST_GIVE_BACK && !bus_grant && ended_q;
   assign busy      = state_q != ST_IDLE;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:      if (launch) state_d = ST_WAIT_DEV;
         ST_WAIT_DEV:  if (dev_req) state_d = ST_ASK;
         ST_ASK:       if (bus_grant) state_d = ST_MOVE;
         ST_MOVE:      if (word_done && (last_word || mode)) state_d = ST_GIVE_BACK;
         ST_GIVE_BACK: if (!bus_grant) state_d = ended_q ? ST_IDLE : ST_WAIT_DEV;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ended_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (launch)                      ended_q <= 1'b0;
         else if (word_done && last_word) ended_q <= 1'b1;
      end
   end

   AST_NO_ASK_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_grant) |-> !bus_req); // R4
   AST_STEAL_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && mode) |=> !bus_req); // R6
   AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && !mode && !last_word) |=> bus_req); // R5
   AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT_DEV) |-> !bus_req); // R4
endmodule

// File: rtl/dma_bus_port.sv
module dma_bus_port #(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_move,
   input  logic          bus_grant,
   input  logic          dev_req,
   input  logic          dir,
   input  logic [AW-1:0] cur_addr,
   input  logic [DW-1:0] mem_rdata,
   input  logic [DW-1:0] dev_rdata,
   output logic          bus_oe,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic          dev_ack,
   output logic [DW-1:0] dev_wdata
);
   logic          strobe;
   logic [AW-1:0] park_addr;
   logic [DW-1:0] park_data;

   initial begin
      if (AW < 1 || DW < 1) $fatal(1, "dma_bus_port: bad width");
   end

   assign bus_oe  = in_move && bus_grant;
   assign strobe  = bus_oe && dev_req;
   assign mem_rd  = strobe && !dir;
   assign mem_wr  = strobe && dir;
   assign dev_ack = strobe;

   generate
      if (PARK_ZERO) begin : g_park_zero
         assign park_addr = '0;
         assign park_data = '0;
      end else begin : g_park_hold
         logic [AW-1:0] last_addr_q;
         logic [DW-1:0] last_data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               last_addr_q <= '0;
               last_data_q <= '0;
            end else if (bus_oe) begin
               last_addr_q <= cur_addr;
               last_data_q <= dev_rdata;
            end
         end
         assign park_addr = last_addr_q;
         assign park_data = last_data_q;
      end
   endgenerate

   assign mem_addr  = bus_oe ? cur_addr : park_addr;
   assign mem_wdata = (bus_oe && dir) ? dev_rdata : park_data;
   assign dev_wdata = mem_rd ? mem_rdata : '0;
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
   parameter int AW        = 16,
   parameter int CW        = 16,
   parameter int DW        = 16,
   parameter int RW        = 16,
   parameter bit PARK_ZERO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_sel,
   input  logic [1:0]    cpu_rsel,
   input  logic          cpu_we,
   input  logic [RW-1:0] cpu_wdata,
   output logic [RW-1:0] cpu_rdata,
   output logic          irq,
   output logic          bus_req,
   input  logic          bus_grant,
   output logic          bus_oe,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          dev_req,
   output logic          dev_ack,
   input  logic [DW-1:0] dev_rdata,
   output logic [DW-1:0] dev_wdata
);
   logic          busy, word_done, finish, last_word, dir, mode, launch, in_move;
   logic [AW-1:0] cur_addr;

   dma_cfg_regs #(.AW(AW), .CW(CW), .RW(RW)) i_regs (
      .clk(clk), .rst_n(rst_n),
      .cpu_sel(cpu_sel), .cpu_rsel(cpu_rsel), .cpu_we(cpu_we),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .busy(busy), .word_done(word_done), .finish(finish),
      .cur_addr(cur_addr), .last_word(last_word),
      .dir(dir), .mode(mode), .launch(launch), .irq(irq)
   );

   dma_seq i_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch), .mode(mode),
      .last_word(last_word), .dev_req(dev_req), .bus_grant(bus_grant),
      .bus_req(bus_req), .in_move(in_move), .word_done(word_done),
      .finish(finish), .busy(busy)
   );

   dma_bus_port #(.AW(AW), .DW(DW), .PARK_ZERO(PARK_ZERO)) i_port (
      .clk(clk), .rst_n(rst_n), .in_move(in_move), .bus_grant(bus_grant),
      .dev_req(dev_req), .dir(dir), .cur_addr(cur_addr),
      .mem_rdata(mem_rdata), .dev_rdata(dev_rdata),
      .bus_oe(bus_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .dev_ack(dev_ack),
      .dev_wdata(dev_wdata)
   );

   AST_STROBE_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (bus_req && bus_grant)); // R3
   AST_IRQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !bus_grant); // R9
endmodule

// File: tb/test_dma_engine.sv
module test_dma_engine;
   localparam int AW = 16, CW = 16, DW = 16, RW = 16;
   localparam logic [15:0] PAT_M = 16'hA5A5;
   localparam logic [15:0] PAT_D = 16'h5A5A;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          cpu_sel = 1'b0, cpu_we = 1'b0;
   logic [1:0]    cpu_rsel = '0;
   logic [RW-1:0] cpu_wdata = '0, cpu_rdata;
   logic          irq, bus_req, bus_oe, mem_rd, mem_wr, dev_ack;
   logic          bus_grant = 1'b0, dev_req = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata, dev_rdata, dev_wdata;

   int total = 0, bad = 0, cyc = 0;
   int n_rise = 0, n_words = 0, first_c = 0, last_c = 0;
   int v_r3 = 0, v_r4 = 0, v_r7 = 0, v_r8 = 0;
   logic [AW-1:0] exp_addr = '0;
   logic prev_br = 1'b0, prev_bg = 1'b0;

   always #4 clk = ~clk;

   assign mem_rdata = mem_addr ^ PAT_M;
   assign dev_rdata = mem_addr ^ PAT_D;

   always @(posedge clk) bus_grant <= rst_n && bus_req;

   dma_engine #(.AW(AW), .CW(CW), .DW(DW), .RW(RW)) i_dma_engine (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_rsel(cpu_rsel),
      .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .irq(irq), .bus_req(bus_req), .bus_grant(bus_grant), .bus_oe(bus_oe),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_req(dev_req),
      .dev_ack(dev_ack), .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor at the falling edge, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (bus_req && !prev_br) n_rise++;
         if (prev_bg && !bus_grant && bus_req) v_r4++;
         if (bus_oe && !(bus_grant && bus_req)) v_r3++;
         if ((mem_rd || mem_wr) && !(bus_oe && dev_ack)) v_r3++;
         if (mem_rd && mem_wr) v_r3++;
         if (mem_rd || mem_wr) begin
            if (n_words == 0) first_c = cyc;
            last_c = cyc;
            if (mem_addr != exp_addr) v_r7++;
            exp_addr = exp_addr + 1'b1;
            if (mem_rd && dev_wdata != (mem_addr ^ PAT_M)) v_r8++;
            if (mem_wr && mem_wdata != (mem_addr ^ PAT_D)) v_r8++;
            n_words++;
         end
      end
      prev_br = bus_req;
      prev_bg = bus_grant;
      if (cyc == 100000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic cpu_write(input logic [1:0] rs, input logic [RW-1:0] d, input bit sel = 1'b1);
      step();
      cpu_sel = sel; cpu_we = 1'b1; cpu_rsel = rs; cpu_wdata = d;
      step();
      cpu_sel = 1'b0; cpu_we = 1'b0;
   endtask

   task automatic cpu_read(input logic [1:0] rs, output logic [RW-1:0] d);
      step();
      cpu_sel = 1'b1; cpu_rsel = rs;
      #1 d = cpu_rdata;
      cpu_sel = 1'b0;
   endtask

   task automatic clear_mon(input logic [AW-1:0] a);
      n_rise = 0; n_words = 0; exp_addr = a;
      v_r3 = 0; v_r4 = 0; v_r7 = 0; v_r8 = 0;
   endtask

   task automatic wait_irq();
      for (int i = 0; i < 300; i++) begin
         if (irq) break;
         step();
      end
   endtask

   task automatic t_reset();
      logic [RW-1:0] d;
      chk(bus_req == 1'b0 && irq == 1'b0 && bus_oe == 1'b0, "R3 reset outputs", {bus_req, irq, bus_oe}, 0);
      cpu_read(2'd2, d);
      chk(d == 16'h0, "R2 reset status", d, 0);
   endtask

   task automatic t_select();
      logic [RW-1:0] d;
      cpu_write(2'd0, 16'h0040);
      cpu_write(2'd0, 16'h0999, 1'b0);
      cpu_read(2'd0, d);
      chk(d == 16'h0040, "R1 write ignored without select", d, 16'h0040);
      step();
      cpu_sel = 1'b0; cpu_rsel = 2'd0;
      #1 chk(cpu_rdata == 16'h0, "R1 read zero without select", cpu_rdata, 0);
      cpu_read(2'd3, d);
      chk(d == 16'h0, "R1 unused code reads zero", d, 0);
   endtask

   task automatic t_zero_count();
      logic [RW-1:0] d;
      clear_mon(16'h0);
      cpu_write(2'd1, 16'h0000);
      cpu_write(2'd2, 16'h0001);
      chk(irq == 1'b1, "R10 irq at once on zero count", irq, 1);
      repeat (5) step();
      chk(n_rise == 0, "R10 no bus request on zero count", n_rise, 0);
      cpu_write(2'd2, 16'h0000);
      chk(irq == 1'b0, "R9 control write clears irq", irq, 0);
   endtask

   task automatic t_burst_read();
      logic [RW-1:0] d;
      clear_mon(16'h0100);
      dev_req = 1'b1;
      cpu_write(2'd0, 16'h0100);
      cpu_write(2'd1, 16'h0004);
      cpu_write(2'd2, 16'h0001);
      wait_irq();
      dev_req = 1'b0;
      chk(irq == 1'b1, "R9 irq after burst", irq, 1);
      chk(n_words == 4, "R7 burst word count", n_words, 4);
      chk(n_rise == 1, "R5 one bus request per burst", n_rise, 1);
      chk(last_c - first_c == 3, "R5 back-to-back words", last_c - first_c, 3);
      chk(v_r7 == 0, "R7 burst address order", v_r7, 0);
      chk(v_r8 == 0, "R8 memory read data to device", v_r8, 0);
      chk(v_r3 == 0, "R3 outputs only when granted", v_r3, 0);
      chk(v_r4 == 0, "R4 no request as grant falls", v_r4, 0);
      cpu_read(2'd0, d);
      chk(d == 16'h0104, "R7 address after burst", d, 16'h0104);
      cpu_read(2'd1, d);
      chk(d == 16'h0, "R7 count after burst", d, 0);
      repeat (3) step();
      chk(irq == 1'b1, "R9 irq held", irq, 1);
      cpu_write(2'd2, 16'h0000);
      chk(irq == 1'b0, "R9 irq cleared", irq, 0);
   endtask

   task automatic t_steal_write();
      logic [RW-1:0] d;
      clear_mon(16'h0200);
      dev_req = 1'b0;
      cpu_write(2'd0, 16'h0200);
      cpu_write(2'd1, 16'h0003);
      cpu_write(2'd2, 16'h0007);
      cpu_read(2'd2, d);
      chk(d == 16'h0007, "R2 status busy/dir/mode", d, 16'h0007);
      cpu_write(2'd0, 16'h0777);
      cpu_write(2'd1, 16'h0009);
      cpu_write(2'd2, 16'h0001);
      cpu_read(2'd0, d);
      chk(d == 16'h0200, "R11 address write ignored when busy", d, 16'h0200);
      cpu_read(2'd1, d);
      chk(d == 16'h0003, "R11 count write ignored when busy", d, 3);
      cpu_read(2'd2, d);
      chk(d == 16'h0007, "R11 launch ignored when busy", d, 16'h0007);
      repeat (4) step();
      chk(n_rise == 0, "R4 no request before device asks", n_rise, 0);
      dev_req = 1'b1;
      wait_irq();
      dev_req = 1'b0;
      chk(n_words == 3, "R6 steal word count", n_words, 3);
      chk(n_rise == 3, "R6 one request per word", n_rise, 3);
      chk(v_r7 == 0, "R7 steal address order", v_r7, 0);
      chk(v_r8 == 0, "R8 device data to memory", v_r8, 0);
      chk(v_r3 == 0, "R3 strobes only when granted", v_r3, 0);
      chk(v_r4 == 0, "R4 release handshake", v_r4, 0);
      cpu_read(2'd0, d);
      chk(d == 16'h0203, "R7 address after steal", d, 16'h0203);
      cpu_read(2'd2, d);
      chk(d == 16'h000E, "R2 status after run", d, 16'h000E);
      cpu_write(2'd2, 16'h0000);
      chk(irq == 1'b0, "R9 irq cleared after steal", irq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_select();
      t_zero_count();
      t_burst_read();
      t_steal_write();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule